// File: doc/BRIEF.md
# Video Status Word and Interrupt Level Unit

This block sits beside the control port of a video display processor. It builds the 16-bit status word returned by a control-port read, and also offers a byte-wide view of it. It works out the interrupt level presented to the host processor. It also models the small write queue in front of video memory, using a count of data-port writes made while the picture is being drawn.

The queue model keeps an empty flag and a full flag, both visible in the status word. A write burst that goes beyond the queue depth makes the block raise a wait request for a fixed number of cycles. The count is cleared again when vertical blanking begins.

Reading the status has side effects. It drops the queue-full flag and the flag that marks a half-written two-word command. The interrupt level is held in a register. That register is reloaded when an enable register is written or when a pending flag changes.

Top module: `vstat_irq_unit`

## Requirements
- R1: After reset, with display enabled, outside vertical blank and at line cycle 0, the status word reads 0x0200 (only bit 9, queue empty, set). The interrupt level is 0, and both the wait request and the command-pending flag are 0.
- R2: Status bit 7 reflects the vertical-interrupt pending input.
- R3: Status bit 3 (vertical blank) reads 1 whenever the vertical-blank input is high or the display-enable input is low.
- R4: Status bit 2 (horizontal blank) reads 1 when the line cycle is 400 or more, and 0 below that.
- R5: A data write during active display (display enabled and not in vertical blank) clears bit 9 and increments the write count. The write that brings the count to 4 or more sets bit 8 (queue full). A data write outside active display leaves the count and both flags unchanged.
- R6: A write during active display that takes the count above 4 raises the wait request. The request holds for exactly 32 consecutive cycles, starting at the clock edge that takes the write.
- R7: A word status read clears bit 8 and the command-pending flag at the next edge. The pending flag is set by the first-command-word strobe.
- R8: On a register-write strobe, the interrupt level becomes 6 if the vertical interrupt is both pending and enabled. Otherwise it becomes 4 if the horizontal interrupt is both pending and enabled. Otherwise it becomes 0. No other level ever appears.
- R9: The interrupt level is reloaded only on a register-write strobe or a change of either pending input. A change of an enable input alone leaves the level as it was.
- R10: The rising edge of the vertical-blank input clears the write count and bit 8, and sets bit 9.
- R11: The byte output carries status bits [15:8] when byte-select is 0, and bits [7:0] when it is 1. A byte read clears the command-pending flag in both cases. Only the high-byte read clears bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cycle | input | 9 | CPU cycles elapsed in the current line (0 to 487) |
| vblank_in | input | 1 | Vertical blanking period from line timing |
| disp_en | input | 1 | Display-enable register bit |
| vint_en | input | 1 | Vertical interrupt enable register bit |
| hint_en | input | 1 | Horizontal interrupt enable register bit |
| vint_pend | input | 1 | Vertical interrupt pending |
| hint_pend | input | 1 | Horizontal interrupt pending |
| reg_wr | input | 1 | Strobe: an interrupt-enable register was written |
| data_wr | input | 1 | Strobe: data-port write |
| cmd_first | input | 1 | Strobe: first word of a two-word command written |
| stat_rd | input | 1 | Strobe: word status read |
| stat_rd_byte | input | 1 | Strobe: byte status read |
| byte_sel | input | 1 | Byte view select: 0 high byte, 1 low byte |
| status_word | output | 16 | Status word |
| status_byte | output | 8 | Selected status byte |
| irq_level | output | 3 | Interrupt level 0, 4 or 6 |
| wait_req | output | 1 | Host wait request |
| cmd_pending | output | 1 | Half-written command flag |

## Verification
The assertions assume the following about the inputs:
- Strobes are single-cycle pulses, sampled at the clock edge.
- The line-cycle input stays within one line.
- Data writes do not arrive in the same cycle as the vertical-blank rising edge.

The directed stimulus respects all of these. Strobes are driven for exactly one cycle, only a few chosen line-cycle values are used, and the vertical-blank input is raised in cycles that have no write. The interrupt-hold property further assumes the pending inputs change only when the bench intends a reload, and the bench changes them only together with a register strobe or as the one event under test.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

    localparam int STAT_W      = 16;
    localparam int BIT_EMPTY   = 9;
    localparam int BIT_FULL    = 8;
    localparam int BIT_VIPEND  = 7;
    localparam int BIT_VBLANK  = 3;
    localparam int BIT_HBLANK  = 2;

    typedef enum logic [2:0] {
        IRQ_NONE  = 3'd0,
        IRQ_HLINE = 3'd4,
        IRQ_VSYNC = 3'd6
    } irq_lvl_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    typedef struct packed {
        fifo_flags_t flags;
        logic        vint_pend;
        logic        vblank;
        logic        hblank;
    } stat_src_t;

    function automatic logic [STAT_W-1:0] build_status(stat_src_t s);
        logic [STAT_W-1:0] w;
        w             = '0;
        w[BIT_EMPTY]  = s.flags.empty;
        w[BIT_FULL]   = s.flags.full;
        w[BIT_VIPEND] = s.vint_pend;
        w[BIT_VBLANK] = s.vblank;
        w[BIT_HBLANK] = s.hblank;
        return w;
    endfunction

    function automatic irq_lvl_t pick_level(logic vp, logic ve, logic hp, logic he);
        if (vp && ve)      return IRQ_VSYNC;
        else if (hp && he) return IRQ_HLINE;
        else               return IRQ_NONE;
    endfunction

endpackage

// File: rtl/vstat_fifo_model.sv
module vstat_fifo_model
    import vstat_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             blank_start,
    input  logic             data_wr,
    input  logic             clr_full,
    output fifo_flags_t      flags,
    output logic [CNT_W-1:0] count,
    output logic             penalty
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic             take;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        take     = data_wr && active;
        cnt_next = (count == CNT_MAX) ? count : count + 1'b1;
        penalty  = take && (cnt_next > DEPTH_C);
    end

    always_ff @(posedge clk) begin
        if (rst || blank_start) begin
            count       <= '0;
            flags.empty <= 1'b1;
            flags.full  <= 1'b0;
        end else if (take) begin
            count       <= cnt_next;
            flags.empty <= 1'b0;
            if (cnt_next >= DEPTH_C) flags.full <= 1'b1;
            else if (clr_full)       flags.full <= 1'b0;
        end else if (clr_full) begin
            flags.full <= 1'b0;
        end
    end
endmodule

// File: rtl/vstat_wait_gen.sv
module vstat_wait_gen #(
    parameter int PENALTY = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic wait_req
);
    localparam int WAIT_W = $clog2(PENALTY + 1);
    localparam logic [WAIT_W-1:0] LOAD = WAIT_W'(PENALTY);

    logic [WAIT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (trigger)       remain <= LOAD;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign wait_req = (remain != '0);
endmodule

// File: rtl/vstat_irq_eval.sv
module vstat_irq_eval
    import vstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     reg_wr,
    input  logic     vint_pend,
    input  logic     vint_en,
    input  logic     hint_pend,
    input  logic     hint_en,
    output irq_lvl_t level
);
    logic [1:0] pend_q;
    logic       reload;

    always_ff @(posedge clk) pend_q <= {vint_pend, hint_pend};

    assign reload = reg_wr || (pend_q != {vint_pend, hint_pend});

    always_ff @(posedge clk) begin
        if (rst)         level <= IRQ_NONE;
        else if (reload) level <= pick_level(vint_pend, vint_en, hint_pend, hint_en);
    end
endmodule

// File: rtl/vstat_irq_unit.sv
module vstat_irq_unit
    import vstat_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int HBLANK_START = 400,
    parameter int CNT_W        = 4,
    parameter int FIFO_DEPTH   = 4,
    parameter int PENALTY      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_cycle,
    input  logic              vblank_in,
    input  logic              disp_en,
    input  logic              vint_en,
    input  logic              hint_en,
    input  logic              vint_pend,
    input  logic              hint_pend,
    input  logic              reg_wr,
    input  logic              data_wr,
    input  logic              cmd_first,
    input  logic              stat_rd,
    input  logic              stat_rd_byte,
    input  logic              byte_sel,
    output logic [15:0]       status_word,
    output logic [7:0]        status_byte,
    output logic [2:0]        irq_level,
    output logic              wait_req,
    output logic              cmd_pending
);
    localparam logic [LINE_W-1:0] HB_C = LINE_W'(HBLANK_START);

    logic             vb_q;
    logic             blank_start;
    logic             active;
    logic             clr_full;
    logic             clr_pend;
    logic             penalty;
    logic [CNT_W-1:0] wr_count;
    fifo_flags_t      flags;
    stat_src_t        src;
    irq_lvl_t         level;

    always_ff @(posedge clk) vb_q <= vblank_in;

    always_comb begin
        blank_start = vblank_in && !vb_q;
        active      = disp_en && !vblank_in;
        clr_full    = stat_rd || (stat_rd_byte && !byte_sel);
        clr_pend    = stat_rd || stat_rd_byte;
    end

    vstat_fifo_model #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .blank_start (blank_start),
        .data_wr     (data_wr),
        .clr_full    (clr_full),
        .flags       (flags),
        .count       (wr_count),
        .penalty     (penalty)
    );

    vstat_wait_gen #(.PENALTY(PENALTY)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .trigger  (penalty),
        .wait_req (wait_req)
    );

    vstat_irq_eval u_irq (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .vint_pend (vint_pend),
        .vint_en   (vint_en),
        .hint_pend (hint_pend),
        .hint_en   (hint_en),
        .level     (level)
    );

    always_ff @(posedge clk) begin
        if (rst)            cmd_pending <= 1'b0;
        else if (cmd_first) cmd_pending <= 1'b1;
        else if (clr_pend)  cmd_pending <= 1'b0;
    end

    always_comb begin
        src.flags     = flags;
        src.vint_pend = vint_pend;
        src.vblank    = vblank_in || !disp_en;
        src.hblank    = (line_cycle >= HB_C);
        status_word   = build_status(src);
        status_byte   = byte_sel ? status_word[7:0] : status_word[15:8];
        irq_level     = level;
    end
endmodule

// File: rtl/vstat_irq_unit_chk.sv
module vstat_irq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        vblank_in,
    input logic        disp_en,
    input logic        vint_pend,
    input logic        hint_pend,
    input logic        reg_wr,
    input logic        data_wr,
    input logic        stat_rd,
    input logic [15:0] status_word,
    input logic [2:0]  irq_level,
    input logic        wait_req
);
    AST_VBLANK_FORCED: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> status_word[3]); // R3

    AST_IRQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (irq_level == 3'd0) || (irq_level == 3'd4) || (irq_level == 3'd6)); // R8

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && ({vint_pend, hint_pend} == $past({vint_pend, hint_pend})))
        |=> $stable(irq_level)); // R9

    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_req) |-> $past(data_wr)); // R6

    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !data_wr) |=> !status_word[8]); // R7

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(status_word[9] && status_word[8])); // R5

    AST_BLANK_RESET: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank_in) |=> (status_word[9] && !status_word[8])); // R10
endmodule

bind vstat_irq_unit vstat_irq_unit_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .vblank_in   (vblank_in),
    .disp_en     (disp_en),
    .vint_pend   (vint_pend),
    .hint_pend   (hint_pend),
    .reg_wr      (reg_wr),
    .data_wr     (data_wr),
    .stat_rd     (stat_rd),
    .status_word (status_word),
    .irq_level   (irq_level),
    .wait_req    (wait_req)
);

// File: tb/test_vstat_irq_unit.sv
`timescale 1ns/1ps
module test_vstat_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  line_cycle = '0;
    logic        vblank_in = 1'b0, disp_en = 1'b1, vint_en = 1'b0, hint_en = 1'b0;
    logic        vint_pend = 1'b0, hint_pend = 1'b0, reg_wr = 1'b0, data_wr = 1'b0;
    logic        cmd_first = 1'b0, stat_rd = 1'b0, stat_rd_byte = 1'b0, byte_sel = 1'b0;
    logic [15:0] status_word;
    logic [7:0]  status_byte;
    logic [2:0]  irq_level;
    logic        wait_req, cmd_pending;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vstat_irq_unit i_vstat_irq_unit (
        .clk(clk), .rst(rst), .line_cycle(line_cycle), .vblank_in(vblank_in),
        .disp_en(disp_en), .vint_en(vint_en), .hint_en(hint_en),
        .vint_pend(vint_pend), .hint_pend(hint_pend), .reg_wr(reg_wr),
        .data_wr(data_wr), .cmd_first(cmd_first), .stat_rd(stat_rd),
        .stat_rd_byte(stat_rd_byte), .byte_sel(byte_sel),
        .status_word(status_word), .status_byte(status_byte),
        .irq_level(irq_level), .wait_req(wait_req), .cmd_pending(cmd_pending)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic write_once();
        data_wr = 1'b1; step(); data_wr = 1'b0;
    endtask

    task automatic blank_pulse();
        vblank_in = 1'b1; step(); step(); vblank_in = 1'b0; step();
    endtask

    task automatic t_reset();
        chk("R1 status", status_word, 32'h0200);
        chk("R1 irq", irq_level, 0);
        chk("R1 wait", wait_req, 0);
        chk("R1 pending", cmd_pending, 0);
    endtask

    task automatic t_static_bits();
        vint_pend = 1'b1; #1;
        chk("R2 vint bit", status_word[7], 1);
        vint_pend = 1'b0; #1;
        chk("R2 vint bit clear", status_word[7], 0);
        disp_en = 1'b0; #1;
        chk("R3 vblank forced", status_word[3], 1);
        disp_en = 1'b1; vblank_in = 1'b0; #1;
        chk("R3 vblank off", status_word[3], 0);
        line_cycle = 9'd399; #1;
        chk("R4 hblank 399", status_word[2], 0);
        line_cycle = 9'd400; #1;
        chk("R4 hblank 400", status_word[2], 1);
        line_cycle = 9'd487; #1;
        chk("R4 hblank 487", status_word[2], 1);
        line_cycle = 9'd0; #1;
    endtask

    task automatic t_fifo_and_wait();
        int highs = 0;
        write_once();
        chk("R5 empty cleared", status_word[9:8], 2'b00);
        write_once(); write_once();
        chk("R5 three writes not full", status_word[8], 0);
        write_once();
        chk("R5 full at four", status_word[9:8], 2'b01);
        chk("R6 no wait at four", wait_req, 0);
        data_wr = 1'b1; #1;
        for (int i = 0; i < 40; i++) begin
            step();
            data_wr = 1'b0;
            if (wait_req) highs++;
        end
        chk("R6 wait length", highs, 32);
        chk("R6 wait released", wait_req, 0);
    endtask

    task automatic t_blank_and_reads();
        blank_pulse();
        chk("R10 blank restores empty", status_word[9:8], 2'b10);
        vblank_in = 1'b1; step();
        write_once();
        chk("R5 write in blank ignored", status_word[9:8], 2'b10);
        vblank_in = 1'b0; disp_en = 1'b0; step();
        write_once();
        chk("R5 write with display off ignored", status_word[9:8], 2'b10);
        disp_en = 1'b1; step();
        repeat (4) write_once();
        cmd_first = 1'b1; step(); cmd_first = 1'b0;
        chk("R7 pending set", cmd_pending, 1);
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        chk("R7 word read clears full", status_word[8], 0);
        chk("R7 word read clears pending", cmd_pending, 0);
        blank_pulse();
        repeat (4) write_once();
        cmd_first = 1'b1; step(); cmd_first = 1'b0;
        byte_sel = 1'b1; #1;
        chk("R11 low byte", status_byte, {24'd0, status_word[7:0]});
        stat_rd_byte = 1'b1; step(); stat_rd_byte = 1'b0;
        chk("R11 low read keeps full", status_word[8], 1);
        chk("R11 low read clears pending", cmd_pending, 0);
        byte_sel = 1'b0; #1;
        chk("R11 high byte", status_byte, 32'h01);
        stat_rd_byte = 1'b1; step(); stat_rd_byte = 1'b0;
        chk("R11 high read clears full", status_word[8], 0);
        blank_pulse();
    endtask

    task automatic t_irq();
        vint_pend = 1'b1; hint_pend = 1'b1; vint_en = 1'b1; hint_en = 1'b1;
        reg_wr = 1'b1; step(); reg_wr = 1'b0;
        chk("R8 level six", irq_level, 6);
        vint_en = 1'b0; step(); step();
        chk("R9 enable change alone holds", irq_level, 6);
        reg_wr = 1'b1; step(); reg_wr = 1'b0;
        chk("R8 level four", irq_level, 4);
        hint_en = 1'b0; reg_wr = 1'b1; step(); reg_wr = 1'b0;
        chk("R8 level zero", irq_level, 0);
        hint_en = 1'b1; step();
        chk("R9 hold at zero", irq_level, 0);
        hint_pend = 1'b0; step(); hint_pend = 1'b1; step();
        chk("R9 pending change reloads", irq_level, 4);
        vint_pend = 1'b0; hint_pend = 1'b0; step();
        chk("R9 pending drop reloads", irq_level, 0);
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_static_bits();
        t_fifo_and_wait();
        t_blank_and_reads();
        t_irq();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule